// File: doc/BRIEF.md
# DMA Channel Transfer-Mode Sequencer

This block sequences one DMA channel through the bus ownership cycle. It decides when the system bus is requested from the processor, when the channel actually moves data, and when the bus is handed back. The answer depends on the programmed transfer mode. A peripheral raises a service request. The block asks the processor for the bus and waits for the grant. It then runs fixed three-cycle byte transfers, each with a read strobe and a write strobe. During each byte it drives the current address, and after each byte it steps the address and decrements the remaining byte count.

There are four modes. Single mode gives the bus back after every byte. Block mode latches the first request and keeps the bus until the count runs out or an external end-of-process input arrives. Demand mode keeps moving bytes only while the request stays high, and resumes from the stored address and count after a pause. Cascade mode moves no data: it passes a downstream controller's bus request upward and passes the grant back down as its acknowledge.

Software sets up the channel through a small write port. It writes the start address, writes the byte count, and then writes the mode. The mode write arms the channel.

Top module: `dma_xfer_seq`

## Requirements
- R1: After reset, `hrq`, `dack`, `rd_stb`, `wr_stb`, `addr_drive` and `tc` are low, `addr_out` is 0, and the channel is disarmed, so `dreq` causes no bus request.
- R2: A write with `cfg_sel`=0 loads the address, `cfg_sel`=1 loads the byte count, and `cfg_sel`=2 loads the mode from `cfg_wdata[1:0]` (0 single, 1 block, 2 demand, 3 cascade). A mode write arms the channel if the count is nonzero or the mode is cascade. Otherwise the channel stays disarmed.
- R3: When the channel is armed in a data mode and idle, `dreq` sampled high raises `hrq` in the next cycle. The first byte begins in the cycle after `hlda` is sampled high while `hrq` is asserted.
- R4: Each byte takes three cycles: read only, then read and write, then write only. `dack` and `addr_drive` stay high for the whole byte. `addr_out` holds the current address for the whole byte and advances by one, modulo 2^ADDR_W, afterwards.
- R5: In single mode, `hrq` and `dack` go low in the cycle after every byte. A further byte starts only through a new request and grant.
- R6: In block mode, a one-cycle `dreq` pulse is enough to move the whole programmed count without releasing the bus.
- R7: In demand mode, a byte that ends with `dreq` low releases the bus. Transfers resume from the stored address and count when `dreq` returns, and the total number of bytes still equals the programmed count.
- R8: `tc` is high for exactly one cycle: the last cycle of the byte that takes the count from 1 to 0. The channel then releases the bus and ignores `dreq` until it is re-armed.
- R9: `eop_in` high in any cycle of a byte ends the operation, in every data mode, once that byte completes. The channel disarms and does not pulse `tc` unless that byte was the last one.
- R10: In cascade mode, `hrq` equals `dreq` and `dack` equals `dreq` AND `hlda` in the same cycle. `rd_stb`, `wr_stb` and `addr_drive` stay low.
- R11: `dack` is never high while `hrq` is low.
- R12: Register writes made while the sequencer is requesting or transferring are discarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write enable |
| cfg_sel | input | 2 | Register select: 0 address, 1 count, 2 mode |
| cfg_wdata | input | ADDR_W | Register write data |
| dreq | input | 1 | Device request, or a downstream controller's bus request in cascade mode |
| hlda | input | 1 | Bus grant from the processor |
| eop_in | input | 1 | External end-of-process |
| hrq | output | 1 | Bus request to the processor |
| dack | output | 1 | Acknowledge to the device or downstream controller |
| rd_stb | output | 1 | Read strobe |
| wr_stb | output | 1 | Write strobe |
| addr_drive | output | 1 | High while the address is driven onto the bus |
| addr_out | output | ADDR_W | Current address register |
| tc | output | 1 | Terminal-count pulse |

## Verification
Two events can land in the same cycle. One is the last cycle of a byte, when the address steps and the count decrements. The other is a register write from the programming port. The bench provokes this by issuing address and count writes in the middle of a block transfer. It judges the result by checking that every later byte uses the uninterrupted address sequence and that `tc` still falls on the byte that exhausts the originally programmed count. A second overlap is end-of-process arriving inside a byte. This is provoked at chosen byte numbers in single, block and demand modes, and judged by the exact number of completed bytes, the final address and the absence of `tc`.

// File: rtl/dmaseq_pkg.sv
package dmaseq_pkg;

    typedef enum logic [1:0] {
        XM_SINGLE  = 2'd0,
        XM_BLOCK   = 2'd1,
        XM_DEMAND  = 2'd2,
        XM_CASCADE = 2'd3
    } xfer_mode_e;

    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_REQ  = 2'd1,
        SQ_MOVE = 2'd2
    } seq_state_e;

    localparam logic [1:0] SEL_ADDR  = 2'd0;
    localparam logic [1:0] SEL_COUNT = 2'd1;
    localparam logic [1:0] SEL_MODE  = 2'd2;

endpackage

// File: rtl/dmaseq_regs.sv
module dmaseq_regs
    import dmaseq_pkg::*;
#(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [ADDR_W-1:0] wr_data,
    input  logic              step,
    input  logic              disarm,
    output logic [ADDR_W-1:0] addr,
    output logic [CNT_W-1:0]  cnt,
    output xfer_mode_e        mode,
    output logic              armed,
    output logic              last_byte
);

    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [CNT_W-1:0]  cnt;
        xfer_mode_e        mode;
        logic              armed;
    } chan_regs_t;

    chan_regs_t regs_q, regs_d;

    always_comb begin
        regs_d = regs_q;
        if (wr_en) begin
            case (wr_sel)
                SEL_ADDR:  regs_d.addr = wr_data;
                SEL_COUNT: regs_d.cnt  = wr_data[CNT_W-1:0];
                SEL_MODE: begin
                    regs_d.mode  = xfer_mode_e'(wr_data[1:0]);
                    regs_d.armed = (wr_data[1:0] == 2'd3) || (regs_q.cnt != '0);
                end
                default: ;
            endcase
        end
        if (step) begin
            regs_d.addr = regs_q.addr + 1'b1;
            regs_d.cnt  = regs_q.cnt - 1'b1;
        end
        if (disarm) begin
            regs_d.armed = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '{addr: '0, cnt: '0, mode: XM_SINGLE, armed: 1'b0};
        end else begin
            regs_q <= regs_d;
        end
    end

    assign addr      = regs_q.addr;
    assign cnt       = regs_q.cnt;
    assign mode      = regs_q.mode;
    assign armed     = regs_q.armed;
    assign last_byte = (regs_q.cnt == CNT_ONE);

    // R2: an arming mode write never arms a data mode with zero count
    a_r2_no_empty_arm: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == SEL_MODE && wr_data[1:0] != 2'd3 && regs_q.cnt == '0 && !step)
        |=> !armed)
        else $error("a_r2_no_empty_arm");

endmodule

// File: rtl/dmaseq_fsm.sv
module dmaseq_fsm
    import dmaseq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       armed,
    input  xfer_mode_e mode,
    input  logic       last_byte,
    input  logic       dreq,
    input  logic       hlda,
    input  logic       eop_in,
    output logic       hrq,
    output logic       dack,
    output logic       rd_stb,
    output logic       wr_stb,
    output logic       addr_drive,
    output logic       tc,
    output logic       step,
    output logic       disarm,
    output logic       idle
);

    localparam int unsigned BYTE_CYC = 3;
    localparam int unsigned PH_W     = $clog2(BYTE_CYC);
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(BYTE_CYC - 1);

    typedef struct packed {
        seq_state_e      st;
        logic [PH_W-1:0] ph;
        logic            eop_seen;
    } seq_t;

    seq_t seq_q, seq_d;

    logic cascade_on;
    logic moving;
    logic byte_end;
    logic eop_now;
    logic stop_now;

    assign cascade_on = armed && (mode == XM_CASCADE);
    assign moving     = (seq_q.st == SQ_MOVE);
    assign byte_end   = moving && (seq_q.ph == PH_LAST);
    assign eop_now    = seq_q.eop_seen || eop_in;
    assign stop_now   = last_byte || eop_now;

    always_comb begin
        seq_d  = seq_q;
        step   = 1'b0;
        disarm = 1'b0;
        case (seq_q.st)
            SQ_IDLE: begin
                if (armed && mode != XM_CASCADE && dreq) begin
                    seq_d.st = SQ_REQ;
                end
            end
            SQ_REQ: begin
                if (hlda) begin
                    seq_d.st       = SQ_MOVE;
                    seq_d.ph       = '0;
                    seq_d.eop_seen = 1'b0;
                end else if (mode == XM_DEMAND && !dreq) begin
                    seq_d.st = SQ_IDLE;
                end
            end
            SQ_MOVE: begin
                seq_d.eop_seen = eop_now;
                if (seq_q.ph != PH_LAST) begin
                    seq_d.ph = seq_q.ph + 1'b1;
                end else begin
                    step           = 1'b1;
                    seq_d.ph       = '0;
                    seq_d.eop_seen = 1'b0;
                    if (stop_now) begin
                        disarm   = 1'b1;
                        seq_d.st = SQ_IDLE;
                    end else if (mode == XM_BLOCK) begin
                        seq_d.st = SQ_MOVE;
                    end else if (mode == XM_DEMAND && dreq) begin
                        seq_d.st = SQ_MOVE;
                    end else begin
                        seq_d.st = SQ_IDLE;
                    end
                end
            end
            default: seq_d.st = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{st: SQ_IDLE, ph: '0, eop_seen: 1'b0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign hrq        = (seq_q.st != SQ_IDLE) || (cascade_on && dreq);
    assign dack       = moving || (cascade_on && dreq && hlda);
    assign rd_stb     = moving && (seq_q.ph != PH_LAST);
    assign wr_stb     = moving && (seq_q.ph != '0);
    assign addr_drive = moving;
    assign tc         = byte_end && last_byte;
    assign idle       = (seq_q.st == SQ_IDLE);

    // R11: acknowledge only while the bus is requested
    a_r11_dack_with_hrq: assert property (@(posedge clk) disable iff (!rst_n)
        dack |-> hrq)
        else $error("a_r11_dack_with_hrq");

    // R3: a transfer is entered only after a sampled grant
    a_r3_grant_first: assert property (@(posedge clk) disable iff (!rst_n)
        (moving && $past(seq_q.st) == SQ_REQ) |-> $past(hlda))
        else $error("a_r3_grant_first");

    // R4: strobe order inside a byte
    a_r4_rd_then_both: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && !wr_stb) |=> (rd_stb && wr_stb))
        else $error("a_r4_rd_then_both");
    a_r4_both_then_wr: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && wr_stb) |=> (wr_stb && !rd_stb))
        else $error("a_r4_both_then_wr");

    // R5: single mode hands the bus back after each byte
    a_r5_single_release: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_end && mode == XM_SINGLE) |=> (!hrq && !dack))
        else $error("a_r5_single_release");

    // R9: a seen end-of-process closes the operation at the byte boundary
    a_r9_eop_stops: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_end && eop_now) |=> (idle && !armed))
        else $error("a_r9_eop_stops");

    // R10: cascade never strobes
    a_r10_cascade_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        cascade_on |-> (!rd_stb && !wr_stb && !addr_drive))
        else $error("a_r10_cascade_quiet");

endmodule

// File: rtl/dma_xfer_seq.sv
module dma_xfer_seq
    import dmaseq_pkg::*;
#(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [ADDR_W-1:0] cfg_wdata,
    input  logic              dreq,
    input  logic              hlda,
    input  logic              eop_in,
    output logic              hrq,
    output logic              dack,
    output logic              rd_stb,
    output logic              wr_stb,
    output logic              addr_drive,
    output logic [ADDR_W-1:0] addr_out,
    output logic              tc
);

    logic              wr_gate;
    logic              step;
    logic              disarm;
    logic              seq_idle;
    logic              armed;
    logic              last_byte;
    logic [CNT_W-1:0]  cnt;
    logic [ADDR_W-1:0] addr_q;
    xfer_mode_e        mode;

    assign wr_gate = cfg_we && seq_idle;

    dmaseq_regs #(
        .ADDR_W (ADDR_W),
        .CNT_W  (CNT_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_gate),
        .wr_sel    (cfg_sel),
        .wr_data   (cfg_wdata),
        .step      (step),
        .disarm    (disarm),
        .addr      (addr_q),
        .cnt       (cnt),
        .mode      (mode),
        .armed     (armed),
        .last_byte (last_byte)
    );

    dmaseq_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .armed      (armed),
        .mode       (mode),
        .last_byte  (last_byte),
        .dreq       (dreq),
        .hlda       (hlda),
        .eop_in     (eop_in),
        .hrq        (hrq),
        .dack       (dack),
        .rd_stb     (rd_stb),
        .wr_stb     (wr_stb),
        .addr_drive (addr_drive),
        .tc         (tc),
        .step       (step),
        .disarm     (disarm),
        .idle       (seq_idle)
    );

    assign addr_out = addr_q;

    // R8: terminal count only on the final byte, and it disarms
    a_r8_tc_on_last: assert property (@(posedge clk) disable iff (!rst_n)
        tc |-> (cnt == CNT_W'(1)))
        else $error("a_r8_tc_on_last");
    a_r8_tc_disarms: assert property (@(posedge clk) disable iff (!rst_n)
        tc |=> (!armed && !hrq))
        else $error("a_r8_tc_disarms");

    // R4: the address moves only through a write or a completed byte
    a_r4_addr_steps: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(addr_q) && !$past(wr_gate)) |-> $past(step))
        else $error("a_r4_addr_steps");

    // R12: writes during a request or transfer leave the registers alone
    a_r12_busy_write: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && !seq_idle && !step) |=> ($stable(addr_q) && $stable(cnt) && $stable(mode)))
        else $error("a_r12_busy_write");

endmodule

// File: tb/dma_xfer_seq_tb.sv
`timescale 1ns/1ps
module dma_xfer_seq_tb;
    import dmaseq_pkg::*;

    localparam int AW = 16;
    localparam int CW = 16;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic          rst_n;
    logic          cfg_we;
    logic [1:0]    cfg_sel;
    logic [AW-1:0] cfg_wdata;
    logic          dreq;
    logic          eop_in;
    logic          hlda_mdl;
    logic          hlda_frc_en;
    logic          hlda_frc;
    logic          hlda;
    logic          hrq, dack, rd_stb, wr_stb, addr_drive, tc;
    logic [AW-1:0] addr_out;

    assign hlda = hlda_frc_en ? hlda_frc : hlda_mdl;

    dma_xfer_seq #(.ADDR_W(AW), .CNT_W(CW)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .dreq(dreq), .hlda(hlda), .eop_in(eop_in),
        .hrq(hrq), .dack(dack), .rd_stb(rd_stb), .wr_stb(wr_stb),
        .addr_drive(addr_drive), .addr_out(addr_out), .tc(tc)
    );

    // processor model: grants one cycle after the request
    always @(posedge clk) hlda_mdl <= rst_n ? hrq : 1'b0;

    int n_chk = 0, n_fail = 0, m_chk = 0, m_fail = 0;

    // main-owned test context
    logic          mon_en = 1'b0;
    xfer_mode_e    cur_mode = XM_SINGLE;
    logic [AW-1:0] t_start = '0;
    int            t_n = 0;
    int            b_base = 0;
    int            tc_base = 0;
    int            s_base = 0;

    // monitor-owned
    int   bytes_started = 0;
    int   bytes_done = 0;
    int   tc_seen = 0;
    int   low_run = 0;
    logic prev_end = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic mchk(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
        m_chk++;
        if (!ok) begin
            m_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        logic [AW-1:0] exp_a;
        exp_a = t_start + AW'(bytes_done - b_base);
        if (!dreq) low_run++; else low_run = 0;
        if (mon_en) begin
            mchk(!dack || hrq, "R11", "dack without hrq", dack, 0);
            if (prev_end && cur_mode == XM_SINGLE)
                mchk(!hrq && !dack, "R5", "bus kept after single byte", hrq, 0);
            if (rd_stb && !wr_stb) begin
                mchk(addr_out == exp_a, "R4", "byte start address", addr_out, exp_a);
                mchk(dack && addr_drive, "R4", "ack/drive in byte", {dack, addr_drive}, 2'b11);
                bytes_started++;
            end
            if (rd_stb && wr_stb)
                mchk(addr_out == exp_a, "R4", "mid byte address", addr_out, exp_a);
            if (tc) begin
                mchk(wr_stb && !rd_stb, "R8", "tc outside last cycle", {rd_stb, wr_stb}, 2'b01);
                mchk(bytes_done - b_base + 1 == t_n, "R8", "tc on byte",
                     bytes_done - b_base + 1, t_n);
                tc_seen++;
            end
            if (cur_mode == XM_DEMAND && low_run >= 5)
                mchk(!hrq, "R7", "bus held with dreq low", hrq, 0);
            prev_end = wr_stb && !rd_stb;
            if (prev_end) bytes_done++;
        end else begin
            prev_end = 1'b0;
        end
    end

    int wd = 0;
    always @(posedge clk) begin
        wd++;
        if (wd > 150000) begin
            $display("FAIL watchdog: actual %0d expected %0d", wd, 150000);
            $display("[TB] %0d tests run, %0d failed", n_chk + m_chk + 1, n_fail + m_fail + 1);
            $finish;
        end
    end

    task automatic prog(input logic [1:0] sel, input logic [AW-1:0] data);
        @(posedge clk); #1;
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
        @(posedge clk); #1;
        cfg_we = 1'b0;
    endtask

    task automatic setup(input xfer_mode_e m, input int n, input logic [AW-1:0] start);
        prog(SEL_ADDR, start);
        prog(SEL_COUNT, AW'(n));
        t_start = start; t_n = n; cur_mode = m;
        b_base = bytes_done; tc_base = tc_seen; s_base = bytes_started;
        mon_en = 1'b1;
        prog(SEL_MODE, AW'(m));
    endtask

    task automatic idle_check(input string req);
        dreq = 1'b1;
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            chk(!hrq, req, "request while disarmed", hrq, 0);
        end
        @(posedge clk); #1;
        dreq = 1'b0;
    endtask

    function automatic string mode_req(input xfer_mode_e m);
        return (m == XM_SINGLE) ? "R5" : (m == XM_BLOCK) ? "R6" : "R7";
    endfunction

    task automatic run_mode(input xfer_mode_e m, input int n, input logic [AW-1:0] start);
        setup(m, n, start);
        for (int k = 0; k < 20 * n + 60; k++) begin
            @(posedge clk); #1;
            case (m)
                XM_SINGLE: dreq = 1'b1;
                XM_BLOCK:  dreq = (k == 0);
                default:   dreq = ((k % 12) < 6);
            endcase
        end
        dreq = 1'b0;
        repeat (4) @(negedge clk);
        chk(bytes_done - b_base == n, mode_req(m), "bytes moved", bytes_done - b_base, n);
        chk(tc_seen - tc_base == 1, "R8", "tc pulses", tc_seen - tc_base, 1);
        chk(addr_out == AW'(start + AW'(n)), "R4", "final address", addr_out, AW'(start + AW'(n)));
        idle_check("R8");
    endtask

    task automatic run_eop(input xfer_mode_e m, input int n, input int at_byte,
                           input logic [AW-1:0] start);
        setup(m, n, start);
        @(posedge clk); #1;
        dreq = 1'b1;
        if (m == XM_BLOCK) begin
            @(posedge clk); #1;
            dreq = 1'b0;
        end
        for (int k = 0; k < 400 && (bytes_started - s_base) < at_byte; k++) @(negedge clk);
        @(posedge clk); #1;
        eop_in = 1'b1;
        @(posedge clk); #1;
        eop_in = 1'b0;
        repeat (20) @(posedge clk);
        #1 dreq = 1'b0;
        repeat (3) @(negedge clk);
        chk(bytes_done - b_base == at_byte, "R9", "bytes before eop stop",
            bytes_done - b_base, at_byte);
        chk(tc_seen == tc_base, "R9", "tc after eop", tc_seen - tc_base, 0);
        chk(addr_out == AW'(start + AW'(at_byte)), "R9", "address after eop",
            addr_out, AW'(start + AW'(at_byte)));
        idle_check("R9");
    endtask

    initial begin
        rst_n = 1'b0; cfg_we = 1'b0; cfg_sel = '0; cfg_wdata = '0;
        dreq = 1'b0; eop_in = 1'b0; hlda_frc_en = 1'b0; hlda_frc = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk({hrq, dack, rd_stb, wr_stb, addr_drive, tc} == 6'b0, "R1", "outputs in reset",
            {hrq, dack, rd_stb, wr_stb, addr_drive, tc}, 0);
        @(posedge clk); #1;
        rst_n = 1'b1;
        @(negedge clk);
        chk(addr_out == '0, "R1", "address after reset", addr_out, 0);
        idle_check("R1");

        // R3: request and grant timing with a held-off grant
        hlda_frc_en = 1'b1; hlda_frc = 1'b0;
        setup(XM_BLOCK, 1, 16'h0040);
        @(posedge clk); #1;
        dreq = 1'b1;
        @(negedge clk);
        chk(!hrq, "R3", "hrq before dreq sampled", hrq, 0);
        @(negedge clk);
        chk(hrq && !dack, "R3", "hrq one cycle after dreq", {hrq, dack}, 2'b10);
        @(posedge clk); #1;
        dreq = 1'b0;
        repeat (3) @(negedge clk);
        chk(hrq && !rd_stb, "R3", "waiting for grant", {hrq, rd_stb}, 2'b10);
        @(posedge clk); #1;
        hlda_frc = 1'b1;
        @(negedge clk);
        chk(!rd_stb, "R3", "no strobe before grant sampled", rd_stb, 0);
        @(negedge clk);
        chk(rd_stb && dack, "R3", "byte after grant", {rd_stb, dack}, 2'b11);
        @(posedge clk); #1;
        hlda_frc_en = 1'b0;
        repeat (8) @(negedge clk);
        chk(bytes_done - b_base == 1, "R3", "one byte moved", bytes_done - b_base, 1);
        chk(tc_seen - tc_base == 1, "R8", "tc on single-count block", tc_seen - tc_base, 1);

        // sweep over data modes and counts
        for (int m = 0; m < 3; m++)
            for (int n = 1; n <= 5; n++)
                run_mode(xfer_mode_e'(m), n, AW'(16'h0100 * (m + 1) + n * 16 - 2));
        run_mode(XM_BLOCK, 4, 16'hFFFE);

        // R9: end-of-process in each data mode
        run_eop(XM_BLOCK, 8, 3, 16'h0200);
        run_eop(XM_SINGLE, 5, 2, 16'h0280);
        run_eop(XM_DEMAND, 6, 1, 16'h02C0);

        // R12: writes during a block transfer are discarded
        setup(XM_BLOCK, 6, 16'h0300);
        @(posedge clk); #1;
        dreq = 1'b1;
        @(posedge clk); #1;
        dreq = 1'b0;
        for (int k = 0; k < 200 && (bytes_started - s_base) < 2; k++) @(negedge clk);
        prog(SEL_ADDR, 16'hDEAD);
        prog(SEL_COUNT, 16'd1);
        repeat (40) @(negedge clk);
        chk(bytes_done - b_base == 6, "R12", "count after busy write", bytes_done - b_base, 6);
        chk(addr_out == 16'h0306, "R12", "address after busy write", addr_out, 16'h0306);
        chk(tc_seen - tc_base == 1, "R12", "tc after busy write", tc_seen - tc_base, 1);

        // R2: zero count leaves the channel disarmed
        prog(SEL_COUNT, 16'd0);
        prog(SEL_MODE, AW'(XM_BLOCK));
        idle_check("R2");

        // R10: cascade relay
        mon_en = 1'b0;
        prog(SEL_MODE, AW'(XM_CASCADE));
        hlda_frc_en = 1'b1;
        for (int c = 0; c < 4; c++) begin
            @(posedge clk); #1;
            dreq = c[0]; hlda_frc = c[1];
            @(negedge clk);
            chk(hrq == c[0], "R10", "relayed request", hrq, c[0]);
            chk(dack == (c[0] & c[1]), "R10", "relayed ack", dack, c[0] & c[1]);
            chk({rd_stb, wr_stb, addr_drive} == 3'b0, "R10", "no bus activity",
                {rd_stb, wr_stb, addr_drive}, 0);
            chk(!dack || hrq, "R11", "dack without hrq in cascade", dack, 0);
        end
        @(posedge clk); #1;
        dreq = 1'b0; hlda_frc_en = 1'b0;
        repeat (2) @(posedge clk);

        $display("[TB] %0d tests run, %0d failed", n_chk + m_chk, n_fail + m_fail);
        $finish;
    end

endmodule